// File: doc/BRIEF.md
# Keyed Rotate-and-Chain Whitening Stage

This stage conditions a raw 32-bit word from a deterministic source so that the emitted word is harder to predict. Two keyed controls act on the word. A 5-bit selector first rotates the word left by that many positions. A single key bit then seeds a serial chain that runs upward from bit 0. Each chain bit is emitted and is also passed on to set the next bit.

The whole transformation is combinational and is captured in one output register. A word offered with `in_valid` high appears at the outputs on the next clock edge, together with a one-cycle `out_valid` strobe. A new word can be offered on every cycle. When `in_valid` is low, the register keeps its last result.

Top module: `keyed_chain_whitener`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle that follows a cycle with `in_valid` high, and 0 after any cycle with `in_valid` low.
- R3: The permuted word is `in_data` rotated left by `rot_sel`. Permuted bit i is `in_data[(i - rot_sel) mod 32]`, so a `rot_sel` of 0 leaves the word unchanged.
- R4: Result bit 0 is `key_bit` XOR permuted bit 0.
- R5: For i from 1 to 31, result bit i is the XNOR of result bit i-1 and permuted bit i. The chain is evaluated from bit 0 upward.
- R6: For a fixed key bit and an input word with no rotational symmetry, each of the 32 `rot_sel` values gives a different result.
- R7: While `in_valid` is low, `out_data` holds its value and ignores `in_data`, `rot_sel` and `key_bit`.
- R8: Words offered on consecutive cycles are each accepted. Each result appears one cycle after its own input, with no bubble between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a word to be whitened this cycle |
| in_data | input | 32 | Raw input word |
| rot_sel | input | 5 | Left-rotation amount applied before the chain |
| key_bit | input | 1 | Seed bit for the chain |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | 32 | Registered whitened word |

## Verification
Two things can happen in the same cycle: the register presents one result, and the next word is accepted with a different rotation and key. The bench provokes this by holding `in_valid` high over consecutive cycles. Each word in the run has its own `rot_sel` and `key_bit`. Every result is compared, in the cycle it is presented, against a bit-serial model of its own input. A mixed-up or delayed capture therefore shows up as a mismatch.

// File: rtl/keyed_chain_whitener.sv
module keyed_chain_whitener #(
  parameter int SEL_W = 5,
  localparam int W = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_data,
  input  logic [SEL_W-1:0] rot_sel,
  input  logic             key_bit,
  output logic             out_valid,
  output logic [W-1:0]     out_data
);

  logic [W-1:0] perm;
  logic [W-1:0] chain;

  // left rotation: bit i takes source bit (i - rot_sel) mod W
  for (genvar i = 0; i < W; i++) begin : g_rot
    localparam logic [SEL_W-1:0] POS = SEL_W'(i);
    logic [SEL_W-1:0] src;
    assign src     = POS - rot_sel;
    assign perm[i] = in_data[src];
  end

  always_comb begin
    chain    = '0;
    chain[0] = key_bit ^ perm[0];
    for (int i = 1; i < W; i++)
      chain[i] = ~(chain[i-1] ^ perm[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= chain;
    end
  end

endmodule

// File: rtl/keyed_chain_whitener_chk.sv
module keyed_chain_whitener_chk #(
  parameter int SEL_W = 5,
  parameter int W = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [W-1:0]     in_data,
  input logic [SEL_W-1:0] rot_sel,
  input logic             key_bit,
  input logic             out_valid,
  input logic [W-1:0]     out_data
);

  logic [2*W-1:0]   dbl;
  logic [W-1:0]     rot_in;
  logic [SEL_W-1:0] lsb_idx;
  logic             lsb_src;

  assign dbl     = {in_data, in_data} << rot_sel;
  assign rot_in  = dbl[2*W-1:W];
  assign lsb_idx = '0 - rot_sel;
  assign lsb_src = in_data[lsb_idx];

  always @(negedge clk)
    if (!rst_n) assert_idle_R1: assert (!out_valid && out_data == '0);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data[0] == ($past(key_bit) ^ $past(lsb_src)));

  // neighbouring result bits recover the rotated input (R3, R5)
  assert_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data[W-1:1] ~^ out_data[W-2:0]) == $past(rot_in[W-1:1]));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

endmodule

bind keyed_chain_whitener keyed_chain_whitener_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/test_keyed_chain_whitener.sv
module test_keyed_chain_whitener;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [4:0]  rot_sel = '0;
  logic        key_bit = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  keyed_chain_whitener i_keyed_chain_whitener (.*);

  function automatic logic [31:0] model(logic [31:0] d, int s, logic k);
    logic [31:0] p, r;
    for (int i = 0; i < 32; i++) p[i] = d[(i - s + 32) % 32];
    r[0] = k ^ p[0];
    for (int i = 1; i < 32; i++) r[i] = ~(r[i-1] ^ p[i]);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] d, int s, logic k, string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; rot_sel = 5'(s); key_bit = k;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_data, model(d, s, k));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 data", out_data, 32'd0);
  endtask

  task automatic t_directed();
    send(32'h0000_0000, 0, 1'b0, "R5 zeros");
    send(32'hFFFF_FFFF, 0, 1'b0, "R5 ones");
    send(32'h0000_0001, 0, 1'b1, "R4 key");
    send(32'h0000_0001, 1, 1'b0, "R3 rot1");
    send(32'h8000_0000, 1, 1'b0, "R3 wrap");
    send(32'h1234_5678, 31, 1'b1, "R3 rot31");
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 2; k++)
      for (int s = 0; s < 32; s++)
        send($urandom, s, k[0], "R3 R4 R5 sweep");
  endtask

  task automatic t_distinct();
    logic [31:0] res [32];
    int dup = 0;
    for (int s = 0; s < 32; s++) begin
      send(32'h0000_00B1, s, 1'b1, "R6 collect");
      res[s] = out_data;
    end
    for (int a = 0; a < 32; a++)
      for (int b = a + 1; b < 32; b++)
        if (res[a] == res[b]) dup++;
    check("R6 duplicates", 32'(dup), 32'd0);
  endtask

  task automatic t_hold();
    logic [31:0] held;
    send(32'hCAFE_0F0F, 7, 1'b1, "R7 load");
    held = out_data;
    for (int n = 0; n < 3; n++) begin
      in_data = $urandom; rot_sel = 5'(n + 3); key_bit = n[0];
      @(negedge clk);
      check("R7 hold", out_data, held);
      check("R2 idle", {31'd0, out_valid}, 32'd0);
    end
  endtask

  task automatic t_b2b();
    logic [31:0] d [4];
    for (int n = 0; n < 4; n++) d[n] = $urandom;
    @(negedge clk);
    for (int n = 0; n < 5; n++) begin
      if (n > 0) begin
        check("R8 valid", {31'd0, out_valid}, 32'd1);
        check("R8 data", out_data, model(d[n-1], 5 * (n - 1) + 2, n[0] ^ 1'b1));
      end
      if (n < 4) begin
        in_valid = 1'b1; in_data = d[n]; rot_sel = 5'(5 * n + 2); key_bit = n[0];
        @(negedge clk);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R2 drop", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #5000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_directed();
    t_sweep();
    t_distinct();
    t_hold();
    t_b2b();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule